// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Array

This block is a bank of output cells for a programmable sum-of-products logic array. Each cell takes the OR-plane result for its pin (the sum term) and delivers it either through a D flip-flop or straight through. It applies a selectable output polarity and drives a tri-state pin model made of a data bit and an enable bit. It also hands a feedback bit back to the array. The bank has three global controls: an asynchronous clear term, a synchronous preset term and a preload strobe used for test. Each cell also has its own output-enable product term.

Two static configuration bits set up each cell. `cfg_comb` picks the path: 0 means registered and 1 means combinatorial. `cfg_pol_hi` picks the polarity: 1 means active-high and 0 means active-low. An unprogrammed bit reads as 0, so an unconfigured cell is registered and active-low. Together the two bits form a four-valued cell mode: MODE_REG_LOW (00), MODE_REG_HIGH (01), MODE_COMB_LOW (10) and MODE_COMB_HIGH (11), written as {cfg_comb, cfg_pol_hi}.

The flip-flop picks its next value from one of three sources, chosen on every rising edge. SRC_PIN is used while preload is active. Otherwise SRC_PRESET is used while the preset term is high. In all other cases SRC_ARRAY takes the sum term. The asynchronous clear and the power-up reset act outside this choice and override it. A cell whose enable term is held low works as a dedicated input: in combinatorial mode its pin value reaches the array through the feedback path.

Top module: `sop_macrocell`

## Requirements
- R1: While `rst_n` is low, every flip-flop is 0. A registered cell then shows 0 on `pin_out` if active-high and 1 if active-low, and its `fb` is 0.
- R2: In registered mode, with preload, preset and clear all inactive, the flip-flop takes `sum_term` on the rising edge of `clk`.
- R3: With `sp_term` high and preload inactive, the flip-flop holds 1 after the next rising edge, whatever `sum_term` is.
- R4: While `ar_term` is high, the flip-flop is 0 at once, with no clock edge needed. This clear wins over preset and over preload on any edge that occurs while it is held.
- R5: With `cfg_pol_hi` = 1, `pin_out` carries the selected value unchanged. With `cfg_pol_hi` = 0, `pin_out` carries its inverse. This holds in both registered and combinatorial modes. Clear and preset act on the flip-flop value before the inversion.
- R6: With `cfg_comb` = 1, `pin_out` follows `sum_term` (after polarity) within the same cycle, with no clock edge, and the flip-flop does not affect it.
- R7: `fb` carries the flip-flop value (true, before polarity) in registered mode and `pin_in` in combinatorial mode.
- R8: Outside preload, `pin_oe` equals the cell's `oe_term`.
- R9: While `preload_en` is high, `pin_oe` is 0 for every cell. On the rising edge each flip-flop loads its `pin_in` bit, and this wins over the preset term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array clock, rising edge |
| rst_n | input | 1 | Power-up reset, active low, clears all flip-flops |
| ar_term | input | 1 | Global asynchronous clear term, active high |
| sp_term | input | 1 | Global synchronous preset term, active high |
| preload_en | input | 1 | Test preload strobe, disables drivers and loads flip-flops from pins |
| sum_term | input | CELLS | Sum term from the OR plane, one bit per cell |
| oe_term | input | CELLS | Output-enable product term, one bit per cell |
| cfg_comb | input | CELLS | Path select per cell: 0 registered, 1 combinatorial |
| cfg_pol_hi | input | CELLS | Polarity per cell: 1 active-high, 0 active-low |
| pin_in | input | CELLS | Level seen on each pin |
| pin_out | output | CELLS | Data driven toward each pin |
| pin_oe | output | CELLS | Driver enable for each pin |
| fb | output | CELLS | Feedback returned to the AND array |

## Verification
Two collisions matter most here. The first is the asynchronous clear arriving in the same cycle as a preset or a preload. The bench raises `ar_term` between two edges, checks that the registered pins flip without a clock, and then holds the clear across an edge where preset and preload are also high. The flip-flops must still read 0 afterwards. The second is preset and preload meeting at one edge: the vector table asserts both, and the pin pattern must come out in the flip-flops rather than all ones.

// File: rtl/sop_mc_pkg.sv
package sop_mc_pkg;

    // Cell mode, encoded as {path select, polarity select}
    typedef enum logic [1:0] {
        MODE_REG_LOW   = 2'b00,
        MODE_REG_HIGH  = 2'b01,
        MODE_COMB_LOW  = 2'b10,
        MODE_COMB_HIGH = 2'b11
    } cell_mode_e;

    // Source for the flip-flop's next value
    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'b00,
        SRC_PRESET = 2'b01,
        SRC_PIN    = 2'b10
    } load_src_e;

    function automatic cell_mode_e decode_mode(input logic comb, input logic pol_hi);
        return cell_mode_e'({comb, pol_hi});
    endfunction

endpackage

// File: rtl/sop_mc_flop.sv
module sop_mc_flop
    import sop_mc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ar_term,
    input  logic sp_term,
    input  logic preload_en,
    input  logic sum_term,
    input  logic pin_in,
    output logic q
);

    load_src_e src;
    logic      d;

    // Priority: preload over preset over array
    always_comb begin
        if (preload_en)
            src = SRC_PIN;
        else if (sp_term)
            src = SRC_PRESET;
        else
            src = SRC_ARRAY;
    end

    always_comb begin
        unique case (src)
            SRC_ARRAY:  d = sum_term;
            SRC_PRESET: d = 1'b1;
            SRC_PIN:    d = pin_in;
            default:    d = 1'b0;
        endcase
    end

    // Power-up reset and the clear term both act without the clock
    always_ff @(posedge clk or negedge rst_n or posedge ar_term) begin
        if (!rst_n || ar_term)
            q <= 1'b0;
        else
            q <= d;
    end

    AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ar_term |-> (q == 1'b0)); // R4

    AST_PRESET_SETS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_term && !preload_en && !ar_term) |=> (ar_term || q)); // R3

    AST_PRELOAD_TAKES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && !ar_term) |=> (ar_term || (q == $past(pin_in)))); // R9

    AST_ARRAY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!preload_en && !sp_term && !ar_term) |=> (ar_term || (q == $past(sum_term)))); // R2

endmodule

// File: rtl/sop_mc_route.sv
module sop_mc_route
    import sop_mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cell_mode_e mode,
    input  logic       q,
    input  logic       sum_term,
    input  logic       pin_in,
    input  logic       oe_term,
    input  logic       preload_en,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       fb
);

    always_comb begin
        unique case (mode)
            MODE_REG_LOW: begin
                pin_out = ~q;
                fb      = q;
            end
            MODE_REG_HIGH: begin
                pin_out = q;
                fb      = q;
            end
            MODE_COMB_LOW: begin
                pin_out = ~sum_term;
                fb      = pin_in;
            end
            MODE_COMB_HIGH: begin
                pin_out = sum_term;
                fb      = pin_in;
            end
            default: begin
                pin_out = 1'b0;
                fb      = 1'b0;
            end
        endcase
    end

    // Driver is held off for the whole preload window
    always_comb begin
        pin_oe = oe_term && !preload_en;
    end

    AST_PRELOAD_DRIVER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |-> !pin_oe); // R9

    AST_REG_HIGH_FB_EQ_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_REG_HIGH) |-> (fb == pin_out)); // R5

    AST_REG_LOW_FB_NE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_REG_LOW) |-> (fb != pin_out)); // R7

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
    import sop_mc_pkg::*;
#(
    parameter int CELLS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ar_term,
    input  logic             sp_term,
    input  logic             preload_en,
    input  logic [CELLS-1:0] sum_term,
    input  logic [CELLS-1:0] oe_term,
    input  logic [CELLS-1:0] cfg_comb,
    input  logic [CELLS-1:0] cfg_pol_hi,
    input  logic [CELLS-1:0] pin_in,
    output logic [CELLS-1:0] pin_out,
    output logic [CELLS-1:0] pin_oe,
    output logic [CELLS-1:0] fb
);

    logic [CELLS-1:0] q_vec;

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        cell_mode_e cell_mode;

        always_comb begin
            cell_mode = decode_mode(cfg_comb[i], cfg_pol_hi[i]);
        end

        sop_mc_flop u_flop (
            .clk        (clk),
            .rst_n      (rst_n),
            .ar_term    (ar_term),
            .sp_term    (sp_term),
            .preload_en (preload_en),
            .sum_term   (sum_term[i]),
            .pin_in     (pin_in[i]),
            .q          (q_vec[i])
        );

        sop_mc_route u_route (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode       (cell_mode),
            .q          (q_vec[i]),
            .sum_term   (sum_term[i]),
            .pin_in     (pin_in[i]),
            .oe_term    (oe_term[i]),
            .preload_en (preload_en),
            .pin_out    (pin_out[i]),
            .pin_oe     (pin_oe[i]),
            .fb         (fb[i])
        );
    end

    AST_OE_FOLLOWS_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_en |-> (pin_oe == oe_term)); // R8

endmodule

// File: tb/sop_macrocell_bench.sv
module sop_macrocell_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CELLS      = 4;
    localparam int NVEC       = 8;
    localparam int VW         = 18;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ar_term, sp_term, preload_en;
    logic [CELLS-1:0] sum_term, oe_term, cfg_comb, cfg_pol_hi, pin_in;
    logic [CELLS-1:0] pin_out, pin_oe, fb;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sop_macrocell #(.CELLS(CELLS)) u_sop_macrocell (
        .clk(clk), .rst_n(rst_n), .ar_term(ar_term), .sp_term(sp_term),
        .preload_en(preload_en), .sum_term(sum_term), .oe_term(oe_term),
        .cfg_comb(cfg_comb), .cfg_pol_hi(cfg_pol_hi), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
    );

    // Entry: {sum, sp, preload, pin, oe, expected flip-flop state}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {4'b1010, 1'b0, 1'b0, 4'b0000, 4'b1111, 4'b1010},
        {4'b0101, 1'b0, 1'b0, 4'b1111, 4'b0011, 4'b0101},
        {4'b0000, 1'b1, 1'b0, 4'b0110, 4'b1010, 4'b1111},
        {4'b0011, 1'b0, 1'b0, 4'b1001, 4'b0101, 4'b0011},
        {4'b1100, 1'b0, 1'b1, 4'b0110, 4'b1111, 4'b0110},
        {4'b0000, 1'b1, 1'b1, 4'b1001, 4'b1111, 4'b1001},
        {4'b1111, 1'b0, 1'b0, 4'b0011, 4'b0000, 4'b1111},
        {4'b0000, 1'b0, 1'b0, 4'b1100, 4'b1111, 4'b0000}
    };

    task automatic check(input string tag, input logic [CELLS-1:0] act, input logic [CELLS-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Cells: 0 reg/high, 1 reg/low, 2 comb/high, 3 comb/low
    function automatic logic [CELLS-1:0] model_out(input logic [3:0] q, input logic [3:0] s);
        return {~s[3], s[2], ~q[1], q[0]};
    endfunction

    function automatic logic [CELLS-1:0] model_fb(input logic [3:0] q, input logic [3:0] p);
        return {p[3], p[2], q[1], q[0]};
    endfunction

    initial begin
        #(CLK_PERIOD * 5000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cfg_comb   = 4'b1100;
        cfg_pol_hi = 4'b0101;
        rst_n      = 1'b0;
        ar_term    = 1'b0;
        sp_term    = 1'b0;
        preload_en = 1'b0;
        sum_term   = 4'b1111;
        oe_term    = 4'b1111;
        pin_in     = 4'b0000;

        // R1: flip-flops held clear through edges while in power-up reset
        repeat (3) @(posedge clk);
        #2;
        check("R1 reg pins in reset", pin_out[1:0], 2'b10);
        check("R1 reg feedback in reset", fb[1:0], 2'b00);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table
        for (int k = 0; k < NVEC; k++) begin
            logic [3:0] v_sum, v_pin, v_oe, v_q;
            logic       v_sp, v_pl;
            {v_sum, v_sp, v_pl, v_pin, v_oe, v_q} = VEC[k];
            @(negedge clk);
            sum_term   = v_sum;
            sp_term    = v_sp;
            preload_en = v_pl;
            pin_in     = v_pin;
            oe_term    = v_oe;
            @(posedge clk);
            #2;
            check($sformatf("R2/R3/R5/R6/R9 pin_out vec %0d", k), pin_out, model_out(v_q, v_sum));
            check($sformatf("R7 fb vec %0d", k), fb, model_fb(v_q, v_pin));
            check($sformatf("R8/R9 pin_oe vec %0d", k), pin_oe, v_oe & ~{CELLS{v_pl}});
        end

        // R6 and R7: combinatorial cells respond with no clock edge
        @(negedge clk);
        oe_term  = 4'b0011;
        sum_term = 4'b0100;
        pin_in   = 4'b1000;
        #1;
        check("R6 comb pins same cycle", pin_out[3:2], 2'b11);
        check("R7 comb feedback from pin", fb[3:2], 2'b10);
        sum_term = 4'b1000;
        pin_in   = 4'b0100;
        #1;
        check("R6 comb pins second change", pin_out[3:2], 2'b00);
        check("R7 dedicated input via feedback", fb[3:2], 2'b01);

        // R3: preset sets the registers (flip-flops currently 0)
        @(negedge clk);
        sp_term  = 1'b1;
        sum_term = 4'b0000;
        @(posedge clk);
        #2;
        check("R3 preset on reg pins", pin_out[1:0], 2'b01);
        @(negedge clk);
        sp_term  = 1'b0;
        sum_term = 4'b1111;
        @(posedge clk);
        #2;
        // R4: clear mid-cycle, no edge
        ar_term = 1'b1;
        #1;
        check("R4 async clear reg pins", pin_out[1:0], 2'b10);
        check("R4 async clear feedback", fb[1:0], 2'b00);
        // R4: clear held across an edge with preset and preload also high
        @(negedge clk);
        sp_term    = 1'b1;
        preload_en = 1'b1;
        pin_in     = 4'b1111;
        @(posedge clk);
        #2;
        check("R4 clear wins over preset and preload", fb[1:0], 2'b00);
        @(negedge clk);
        ar_term    = 1'b0;
        sp_term    = 1'b0;
        preload_en = 1'b0;
        sum_term   = 4'b0110;
        @(posedge clk);
        #2;
        check("R2 capture after clear release", pin_out[1:0], 2'b00);
        check("R2 capture feedback", fb[1:0], 2'b10);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule